// File: doc/BRIEF.md
# Cache Error Trap Dispatch Unit

This block sits between a processor's external-cache and system-bus error detectors and its trap logic. Each error event arrives as a one-cycle strobe. The strobe carries three things: an error class, the operation that was under way, and a flag saying whether the failing access came from the system bus or from an external-cache read. The block uses these together with a software-written enable register to pick at most one trap. The trap is presented as a registered single-cycle pulse on one of four request lines: fast ECC, instruction access, data access, or disrupting ECC.

Every accepted event also sets one bit in a sticky fault status register, whatever the enables say. Software clears status bits by writing ones to them. If an event and a clear hit the same bit in the same cycle, the event wins.

The same enable register holds two error-injection controls, one for data check bits and one for tag check bits. While a force bit is set, every cache write leaves the block carrying the forced check-bit field in place of the check bits computed upstream.

Top module: `err_trap_dispatch`

## Requirements
- R1: The enable register is loaded from `en_wdata_i` when `en_we_i` is high. Its fields are:
  - bit 0: corrected-error trap enable
  - bit 1: uncorrectable/system-error trap enable
  - bit 3: fast ECC trap enable
  - bits 12:4: forced data check value, with bit 13 as the data force enable
  - bits 17:14: forced tag check value, with bit 18 as the tag force enable

  The event and operation encodings are:
  - class: 0 software-correctable, 1 uncorrectable, 2 hardware-corrected, 3 bus error, 4 timeout
  - operation: 0 instruction fetch, 1 load, 2 atomic, 3 store merge, 4 writeback, 5 copyout, 6 interrupt-vector fetch
- R2: A fast ECC trap is raised when the fast enable is set and the event is either of these, on an operation of 0, 1 or 2:
  - a software-correctable error, with any source
  - an uncorrectable error with the source flag at 0 (external-cache read)
- R3: Operations 3, 4 and 5 never raise the fast ECC trap. An uncorrectable error on these operations takes the system-error routing of R4.
- R4: With the uncorrectable enable set, the following events are routed by operation: bus-sourced uncorrectable errors, cache-sourced uncorrectable errors on operations other than 0..2, bus errors and timeouts. Operation 0 raises instruction access. Operations 1, 2 and 6 raise data access. Operations 3, 4 and 5 raise disrupting ECC.
- R5: A hardware-corrected error raises disrupting ECC on any operation when the corrected-error enable is set.
- R6: Every accepted event sets exactly one status bit, whatever the enables are:
  - bit 0: software-correctable
  - bit 1: uncorrectable on the fast path of R2
  - bit 2: hardware-corrected
  - bit 3: uncorrectable on the system-error path of R4
  - bit 4: bus error
  - bit 5: timeout
- R7: Status bits stay set until software writes 1 to that position with `stat_clr_we_i`. A set and a clear of the same bit in one cycle leave the bit set.
- R8: A trap output goes high for exactly one cycle, in the cycle after the strobe is sampled. At most one trap line is high at a time.
- R9: Events with class 5..7 or operation 7 raise no trap and set no status bit.
- R10: On a cache write, `data_chk_o` is registered one cycle later. It carries the forced data value if data force is set, and `data_chk_i` otherwise. `chk_valid_o` marks that cycle.
- R11: On a cache write, `tag_chk_o` carries the forced tag value if tag force is set, and `tag_chk_i` otherwise, with the same timing as R10.
- R12: Synchronous reset clears all of the following: the enables, status, trap outputs and check outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 19 | Enable register write data |
| evt_valid_i | input | 1 | Error event strobe |
| evt_class_i | input | 3 | Error class code |
| evt_op_i | input | 3 | Originating operation code |
| evt_bus_i | input | 1 | 1 when the failing access came from the system bus |
| stat_clr_we_i | input | 1 | Status clear strobe |
| stat_clr_mask_i | input | 6 | Ones clear the matching status bits |
| stat_o | output | 6 | Sticky fault status |
| trap_fast_o | output | 1 | Fast ECC trap pulse |
| trap_iacc_o | output | 1 | Instruction access error trap pulse |
| trap_dacc_o | output | 1 | Data access error trap pulse |
| trap_disr_o | output | 1 | Disrupting ECC trap pulse |
| cache_wr_i | input | 1 | Cache write in progress |
| data_chk_i | input | 9 | Computed data check bits |
| tag_chk_i | input | 4 | Computed tag check bits |
| chk_valid_o | output | 1 | Check-bit outputs valid |
| data_chk_o | output | 9 | Data check bits to store |
| tag_chk_o | output | 4 | Tag check bits to store |

## Verification
The bench sweeps every class, operation, source flag and enable combination against a model of its own. This catches two likely mistakes. A design that routed by class alone would send store-path uncorrectable errors to the fast trap. A design that gated logging with the enables would leave status empty when traps are off. Reserved codes are swept too, so a design that let them through would show a stray status bit. The same-cycle set/clear case catches a design that gave the clear priority, because the bit would read zero. The force tests compare forced and pass-through check bits field by field, which exposes a swapped or misaligned field.

// File: rtl/etd_pkg.sv
package etd_pkg;
  localparam int STAT_W = 6;

  localparam logic [2:0] CLS_SWC  = 3'd0;
  localparam logic [2:0] CLS_UNC  = 3'd1;
  localparam logic [2:0] CLS_HWC  = 3'd2;
  localparam logic [2:0] CLS_BERR = 3'd3;
  localparam logic [2:0] CLS_TOUT = 3'd4;

  localparam logic [2:0] OP_FETCH = 3'd0;
  localparam logic [2:0] OP_LOAD  = 3'd1;
  localparam logic [2:0] OP_ATOM  = 3'd2;
  localparam logic [2:0] OP_MERGE = 3'd3;
  localparam logic [2:0] OP_WB    = 3'd4;
  localparam logic [2:0] OP_COPY  = 3'd5;
  localparam logic [2:0] OP_IVEC  = 3'd6;

  localparam int ST_SWC      = 0;
  localparam int ST_UNC_FAST = 1;
  localparam int ST_HWC      = 2;
  localparam int ST_UNC_SYS  = 3;
  localparam int ST_BERR     = 4;
  localparam int ST_TOUT     = 5;

  typedef struct packed {
    logic fast;
    logic iacc;
    logic dacc;
    logic disr;
  } trap_vec_t;
endpackage

// File: rtl/etd_classify.sv
module etd_classify
  import etd_pkg::*;
(
  input  logic              valid_i,
  input  logic [2:0]        cls_i,
  input  logic [2:0]        op_i,
  input  logic              from_bus_i,
  input  logic              en_ce_i,
  input  logic              en_nc_i,
  input  logic              en_fast_i,
  output trap_vec_t         trap_o,
  output logic [STAT_W-1:0] set_o
);
  logic live, op_read, op_store, unc_fast, fast_kind, nc_kind;

  always_comb begin
    live      = valid_i && (op_i != 3'd7) && (cls_i <= CLS_TOUT);
    op_read   = (op_i == OP_FETCH) || (op_i == OP_LOAD) || (op_i == OP_ATOM);
    op_store  = (op_i == OP_MERGE) || (op_i == OP_WB) || (op_i == OP_COPY);
    unc_fast  = (cls_i == CLS_UNC) && !from_bus_i && op_read;
    fast_kind = ((cls_i == CLS_SWC) && op_read) || unc_fast;
    nc_kind   = ((cls_i == CLS_UNC) && !unc_fast) || (cls_i == CLS_BERR) ||
                (cls_i == CLS_TOUT);

    trap_o.fast = live && fast_kind && en_fast_i;
    trap_o.iacc = live && nc_kind && en_nc_i && (op_i == OP_FETCH);
    trap_o.dacc = live && nc_kind && en_nc_i && !op_store && (op_i != OP_FETCH);
    trap_o.disr = live && ((nc_kind && en_nc_i && op_store) ||
                           ((cls_i == CLS_HWC) && en_ce_i));

    set_o              = '0;
    set_o[ST_SWC]      = live && (cls_i == CLS_SWC);
    set_o[ST_UNC_FAST] = live && unc_fast;
    set_o[ST_HWC]      = live && (cls_i == CLS_HWC);
    set_o[ST_UNC_SYS]  = live && (cls_i == CLS_UNC) && !unc_fast;
    set_o[ST_BERR]     = live && (cls_i == CLS_BERR);
    set_o[ST_TOUT]     = live && (cls_i == CLS_TOUT);
  end

  always_comb begin
    AST_ONE_STATUS: assert ($onehot0(set_o)); // R6
  end
endmodule

// File: rtl/etd_status.sv
module etd_status #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_mask_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] clr_eff;
  assign clr_eff = clr_we_i ? clr_mask_i : '0;

  always_ff @(posedge clk) begin
    if (rst) stat_o <= '0;
    else     stat_o <= (stat_o & ~clr_eff) | set_i;
  end

  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (($past(stat_o) & ~$past(clr_eff) & ~stat_o) == '0)); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (($past(set_i) & ~stat_o) == '0)); // R7
endmodule

// File: rtl/etd_chk_mux.sv
module etd_chk_mux #(
  parameter int DW = 9,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic [DW-1:0] data_chk_i,
  input  logic [TW-1:0] tag_chk_i,
  input  logic          force_d_i,
  input  logic [DW-1:0] force_d_val_i,
  input  logic          force_t_i,
  input  logic [TW-1:0] force_t_val_i,
  output logic          valid_o,
  output logic [DW-1:0] data_chk_o,
  output logic [TW-1:0] tag_chk_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o    <= 1'b0;
      data_chk_o <= '0;
      tag_chk_o  <= '0;
    end else begin
      valid_o <= wr_i;
      if (wr_i) begin
        data_chk_o <= force_d_i ? force_d_val_i : data_chk_i;
        tag_chk_o  <= force_t_i ? force_t_val_i : tag_chk_i;
      end
    end
  end

  AST_VALID_FOLLOWS_WR: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(wr_i)); // R10
endmodule

// File: rtl/err_trap_dispatch.sv
module err_trap_dispatch
  import etd_pkg::*;
#(
  parameter int DCHK_W = 9,
  parameter int TCHK_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en_we_i,
  input  logic [DCHK_W+TCHK_W+5:0] en_wdata_i,
  input  logic                     evt_valid_i,
  input  logic [2:0]               evt_class_i,
  input  logic [2:0]               evt_op_i,
  input  logic                     evt_bus_i,
  input  logic                     stat_clr_we_i,
  input  logic [STAT_W-1:0]        stat_clr_mask_i,
  output logic [STAT_W-1:0]        stat_o,
  output logic                     trap_fast_o,
  output logic                     trap_iacc_o,
  output logic                     trap_dacc_o,
  output logic                     trap_disr_o,
  input  logic                     cache_wr_i,
  input  logic [DCHK_W-1:0]        data_chk_i,
  input  logic [TCHK_W-1:0]        tag_chk_i,
  output logic                     chk_valid_o,
  output logic [DCHK_W-1:0]        data_chk_o,
  output logic [TCHK_W-1:0]        tag_chk_o
);
  localparam int B_CE   = 0;
  localparam int B_NC   = 1;
  localparam int B_FAST = 3;
  localparam int FD_LSB = 4;
  localparam int FD_MSB = FD_LSB + DCHK_W - 1;
  localparam int FD_EN  = FD_MSB + 1;
  localparam int FT_LSB = FD_EN + 1;
  localparam int FT_MSB = FT_LSB + TCHK_W - 1;
  localparam int FT_EN  = FT_MSB + 1;

  logic              en_ce_q, en_nc_q, en_fast_q, fd_en_q, ft_en_q;
  logic [DCHK_W-1:0] fd_val_q;
  logic [TCHK_W-1:0] ft_val_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_ce_q   <= 1'b0;
      en_nc_q   <= 1'b0;
      en_fast_q <= 1'b0;
      fd_en_q   <= 1'b0;
      ft_en_q   <= 1'b0;
      fd_val_q  <= '0;
      ft_val_q  <= '0;
    end else if (en_we_i) begin
      en_ce_q   <= en_wdata_i[B_CE];
      en_nc_q   <= en_wdata_i[B_NC];
      en_fast_q <= en_wdata_i[B_FAST];
      fd_en_q   <= en_wdata_i[FD_EN];
      ft_en_q   <= en_wdata_i[FT_EN];
      fd_val_q  <= en_wdata_i[FD_MSB:FD_LSB];
      ft_val_q  <= en_wdata_i[FT_MSB:FT_LSB];
    end
  end

  trap_vec_t         trap_d, trap_q;
  logic [STAT_W-1:0] set_d;

  etd_classify u_cls (
    .valid_i    (evt_valid_i),
    .cls_i      (evt_class_i),
    .op_i       (evt_op_i),
    .from_bus_i (evt_bus_i),
    .en_ce_i    (en_ce_q),
    .en_nc_i    (en_nc_q),
    .en_fast_i  (en_fast_q),
    .trap_o     (trap_d),
    .set_o      (set_d)
  );

  always_ff @(posedge clk) begin
    if (rst) trap_q <= '0;
    else     trap_q <= trap_d;
  end

  assign trap_fast_o = trap_q.fast;
  assign trap_iacc_o = trap_q.iacc;
  assign trap_dacc_o = trap_q.dacc;
  assign trap_disr_o = trap_q.disr;

  etd_status #(.W(STAT_W)) u_stat (
    .clk        (clk),
    .rst        (rst),
    .set_i      (set_d),
    .clr_we_i   (stat_clr_we_i),
    .clr_mask_i (stat_clr_mask_i),
    .stat_o     (stat_o)
  );

  etd_chk_mux #(.DW(DCHK_W), .TW(TCHK_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_i          (cache_wr_i),
    .data_chk_i    (data_chk_i),
    .tag_chk_i     (tag_chk_i),
    .force_d_i     (fd_en_q),
    .force_d_val_i (fd_val_q),
    .force_t_i     (ft_en_q),
    .force_t_val_i (ft_val_q),
    .valid_o       (chk_valid_o),
    .data_chk_o    (data_chk_o),
    .tag_chk_o     (tag_chk_o)
  );

  AST_ONE_TRAP: assert property (@(posedge clk) disable iff (rst)
    $onehot0({trap_fast_o, trap_iacc_o, trap_dacc_o, trap_disr_o})); // R8
  AST_TRAP_NEEDS_EVT: assert property (@(posedge clk) disable iff (rst)
    (trap_fast_o || trap_iacc_o || trap_dacc_o || trap_disr_o) |-> $past(evt_valid_i)); // R8
  AST_NO_FAST_ON_STORE: assert property (@(posedge clk) disable iff (rst)
    trap_fast_o |-> ($past(evt_op_i) <= OP_ATOM)); // R3
  AST_TRAP_LOGGED: assert property (@(posedge clk) disable iff (rst)
    (trap_fast_o || trap_iacc_o || trap_dacc_o || trap_disr_o) |-> (stat_o != '0)); // R6
endmodule

// File: tb/sim_err_trap_dispatch.sv
module sim_err_trap_dispatch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en_we = 1'b0;
  logic [18:0] en_wdata = '0;
  logic        evt_valid = 1'b0;
  logic [2:0]  evt_class = '0;
  logic [2:0]  evt_op = '0;
  logic        evt_bus = 1'b0;
  logic        clr_we = 1'b0;
  logic [5:0]  clr_mask = '0;
  logic [5:0]  stat;
  logic        t_fast, t_iacc, t_dacc, t_disr;
  logic        cache_wr = 1'b0;
  logic [8:0]  dchk_in = '0;
  logic [3:0]  tchk_in = '0;
  logic        chk_valid;
  logic [8:0]  dchk_out;
  logic [3:0]  tchk_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  err_trap_dispatch u0 (
    .clk(clk), .rst(rst), .en_we_i(en_we), .en_wdata_i(en_wdata),
    .evt_valid_i(evt_valid), .evt_class_i(evt_class), .evt_op_i(evt_op),
    .evt_bus_i(evt_bus), .stat_clr_we_i(clr_we), .stat_clr_mask_i(clr_mask),
    .stat_o(stat), .trap_fast_o(t_fast), .trap_iacc_o(t_iacc),
    .trap_dacc_o(t_dacc), .trap_disr_o(t_disr), .cache_wr_i(cache_wr),
    .data_chk_i(dchk_in), .tag_chk_i(tchk_in), .chk_valid_o(chk_valid),
    .data_chk_o(dchk_out), .tag_chk_o(tchk_out)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected traps packed {fast,iacc,dacc,disr}
  function automatic int model_trap(int c, int o, int b, int e);
    bit ce = e[0], nc = e[1], fe = e[2];
    bit rd = (o <= 2);
    bit st = (o >= 3 && o <= 5);
    if (c > 4 || o == 7) return 0;
    if (c == 2) return ce ? 1 : 0;
    if ((c == 0 && rd) || (c == 1 && b == 0 && rd)) return fe ? 8 : 0;
    if (c == 0) return 0;
    if (!nc) return 0;
    if (o == 0) return 4;
    if (st) return 1;
    return 2;
  endfunction

  function automatic int model_stat(int c, int o, int b);
    if (c > 4 || o == 7) return 0;
    case (c)
      0: return 1;
      1: return (b == 0 && o <= 2) ? 2 : 8;
      2: return 4;
      3: return 16;
      default: return 32;
    endcase
  endfunction

  function automatic string tag_of(int c, int o, int b);
    if (c > 4 || o == 7) return "R9";
    if (c == 2) return "R5";
    if (o >= 3 && o <= 5) return "R3";
    if (c == 0 || (c == 1 && b == 0 && o <= 2)) return "R2";
    return "R4";
  endfunction

  function automatic int traps();
    return {28'd0, t_fast, t_iacc, t_dacc, t_disr};
  endfunction

  task automatic event_once(input int c, input int o, input int b);
    evt_valid = 1'b1;
    evt_class = 3'(c);
    evt_op = 3'(o);
    evt_bus = b[0];
    tick();
    evt_valid = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    // R12: reset state
    check("R12 status", int'(stat), 0);
    check("R12 traps", traps(), 0);
    check("R12 chk", int'({chk_valid, dchk_out, tchk_out}), 0);

    // R1..R6, R8, R9 sweep
    for (int c = 0; c < 8; c++)
      for (int o = 0; o < 8; o++)
        for (int b = 0; b < 2; b++)
          for (int e = 0; e < 8; e++) begin
            en_we = 1'b1;
            en_wdata = 19'((e[2] << 3) | (e[1] << 1) | e[0]);
            tick();
            en_we = 1'b0;
            event_once(c, o, b);
            check(tag_of(c, o, b), traps(), model_trap(c, o, b, e));
            check("R6 log", int'(stat), model_stat(c, o, b));
            clr_we = 1'b1;
            clr_mask = '1;
            tick();
            clr_we = 1'b0;
            check("R8 pulse", traps(), 0);
            check("R7 clear", int'(stat), 0);
          end

    // R7: stickiness, set priority, partial clear
    event_once(3, 1, 1);
    tick(); tick();
    check("R7 sticky", int'(stat), 'h10);
    evt_valid = 1'b1; evt_class = 3'd2; evt_op = 3'd4;
    clr_we = 1'b1; clr_mask = 6'h3F;
    tick();
    evt_valid = 1'b0; clr_we = 1'b0;
    check("R7 set wins", int'(stat), 'h04);
    event_once(4, 0, 1);
    check("R7 accum", int'(stat), 'h24);
    clr_we = 1'b1; clr_mask = 6'h20;
    tick();
    clr_we = 1'b0;
    check("R7 partial", int'(stat), 'h04);
    // R8: back-to-back events give two pulses
    en_we = 1'b1; en_wdata = 19'h2; tick(); en_we = 1'b0;
    evt_valid = 1'b1; evt_class = 3'd3; evt_op = 3'd0;
    tick();
    check("R8 first", traps(), 4);
    evt_op = 3'd1;
    tick();
    evt_valid = 1'b0;
    check("R8 second", traps(), 2);

    // R10/R11: check-bit forcing
    dchk_in = 9'h0F3; tchk_in = 4'h6;
    cache_wr = 1'b1; tick(); cache_wr = 1'b0;
    check("R10 pass data", int'({chk_valid, dchk_out}), 'h2F3);
    check("R11 pass tag", int'(tchk_out), 'h6);
    tick();
    check("R10 valid drop", int'(chk_valid), 0);
    en_we = 1'b1;
    en_wdata = 19'((1 << 13) | (9'h1A5 << 4));
    tick(); en_we = 1'b0;
    cache_wr = 1'b1; tick(); cache_wr = 1'b0;
    check("R10 force data", int'(dchk_out), 'h1A5);
    check("R11 no tag force", int'(tchk_out), 'h6);
    en_we = 1'b1;
    en_wdata = 19'((1 << 18) | (4'h9 << 14));
    tick(); en_we = 1'b0;
    cache_wr = 1'b1; tick(); cache_wr = 1'b0;
    check("R10 data released", int'(dchk_out), 'h0F3);
    check("R11 force tag", int'(tchk_out), 'h9);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule